// File: doc/BRIEF.md
# NAND Sector Read Sequencer

This engine copies a contiguous region of a small-page NAND flash into a byte-wide memory write port. No processor takes part in the copy. A requester presents a flash start address, a byte count and a destination base, then pulses `go`. The engine first checks that the start address and the count are both whole multiples of the sector size. A request that fails this check is refused at once with an error status, and the flash is never touched.

An accepted request is split into sectors. For each sector the engine does the following, in order:

- it clears its record of a ready edge;
- it issues the page-read command;
- it sends four address bytes;
- it waits for the device's ready/busy line to rise;
- it moves the sector's bytes to memory, one byte per clock.

The destination address advances together with the flash address. Chip enable stays active from the first sector until the last byte has been moved. The end of the request is marked by a single `done` pulse with an `ok` status.

The flash side is a plain cycle interface. It has one-cycle strobes for command, address and data-read cycles, a shared byte bus for commands and addresses, an active-low chip enable and an asynchronous ready/busy input. Read data is taken combinationally during the data strobe.

Top module: `nand_sector_copier`

## Requirements
- R1: A request is refused when the start address or the length has a nonzero bit in its low log2(SECT) bits, with SECT = 512. A refused request gives `done` high with `ok` = 0 in the cycle after `go` is sampled. Chip enable stays high, and no command, address or data strobe occurs.
- R2: A request with length zero and an aligned start gives `done` with `ok` = 1 in the cycle after `go`. Chip enable is never asserted low for it.
- R3: `nf_ce_n` is low during every command, address and data strobe. It goes low once per accepted request, before the first command. It returns high only after the last data read, and it is high in the `done` cycle and whenever `busy` is low.
- R4: Each sector starts with exactly one command strobe carrying the byte value 0x00 on `nf_wdata`. At most one of the three strobes is high in any cycle.
- R5: After each command come exactly four address strobes. For the sector start address A, zero-extended, they carry A[7:0], A[16:9], A[24:17] and A[32:25], in that order. Bit 8 is never sent.
- R6: No data strobe occurs until the ready/busy input has made a low-to-high transition after that sector's command. A rising edge that happened before the command, for example during the previous sector's data phase, does not count. The input passes through a two-flop synchronizer before edge detection.
- R7: Each sector makes exactly 512 data strobes. In each of them `mem_we` is high and `mem_wdata` equals bits [7:0] of `nf_rdata`. The upper bits of `nf_rdata` are discarded.
- R8: The k-th byte of a request is read from flash address start+k and written to `mem_addr` = dst_base+k. There are length/512 sectors, and the request ends when start+k reaches start+length.
- R9: `busy` is low after reset. It is high from the cycle after an accepted `go` through the `done` cycle, and low in the cycle after. `done` is a one-cycle pulse.
- R10: A `go` pulse while `busy` is high is ignored. The running transfer keeps its byte count, its addresses and its single `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, sampled while not busy |
| start_addr | input | AW (32) | Flash byte address of the first byte |
| byte_len | input | LW (32) | Number of bytes to copy |
| dst_base | input | DAW (32) | Destination address of the first byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| ok | output | 1 | Status, valid with `done`: 1 success, 0 refused |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cmd_we | output | 1 | Command-cycle strobe |
| nf_addr_we | output | 1 | Address-cycle strobe |
| nf_data_re | output | 1 | Data-read strobe |
| nf_wdata | output | 8 | Command or address byte |
| nf_rdy | input | 1 | Asynchronous ready/busy from the flash, high when ready |
| nf_rdata | input | DW (32) | Read data, valid during `nf_data_re` |
| mem_we | output | 1 | Destination write enable |
| mem_addr | output | DAW (32) | Destination address |
| mem_wdata | output | 8 | Destination byte |

## Verification
The bound checker watches, on every clock, the properties that only need the ports:

- chip enable covers every strobe;
- the command byte is 0x00 and the strobes are mutually exclusive;
- no read happens without a ready rise since the last command;
- writes follow reads and carry the low data byte;
- destination addresses step by one from the base;
- a refused or empty request completes in the cycle after `go`;
- `done` is a single pulse;
- a `go` during busy does not end the request.

Only the bench scenarios can show the rest. That covers the exact order and values of the four address bytes, the count of 512 reads per sector and of sectors per request, and the data landing at the correct flash-to-memory pairing. It also covers the rejection of a stale ready edge raised during the previous sector's data phase.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_CMD,
        ST_ADDR,
        ST_WAIT,
        ST_DATA,
        ST_FIN
    } nsr_state_e;

    // Page-read opcode issued at the start of every sector
    localparam logic [7:0] PAGE_READ_OP = 8'h00;

    // Number of address cycles per sector
    localparam int unsigned ADDR_CYCLES = 4;

endpackage

// File: rtl/nsr_rdy_edge.sv
// Synchronizes the asynchronous ready/busy line, detects its rising edge
// and holds a sticky flag until the sequencer clears it.
module nsr_rdy_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_async,
    input  logic flag_clr,
    output logic flag
);

    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its delayed copy
    logic [STAGES:0] chain_q;
    logic [STAGES:0] chain_d;
    logic            flag_q;
    logic            flag_d;
    logic            rise;

    always_comb begin
        chain_d[0] = rdy_async;
    end

    for (genvar s = 1; s <= STAGES; s++) begin : g_chain
        always_comb begin
            chain_d[s] = chain_q[s-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    always_comb begin
        if (flag_clr) begin
            flag_d = 1'b0;
        end else begin
            flag_d = flag_q | rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            flag_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            flag_q  <= flag_d;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/nsr_addr_split.sv
// Selects one of the four address bytes of a sector start address.
// Bit 8 is the column half-select of a small-page device and is never sent.
module nsr_addr_split #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    idx,
    output logic [7:0]    abyte
);

    localparam int unsigned WW = (AW > 33) ? AW : 33;

    logic [WW-1:0] wide;
    logic          unused_half_sel;

    assign wide            = WW'(addr);
    assign unused_half_sel = wide[8];

    always_comb begin
        unique case (idx)
            2'd0:    abyte = wide[7:0];
            2'd1:    abyte = wide[16:9];
            2'd2:    abyte = wide[24:17];
            default: abyte = wide[32:25];
        endcase
    end

endmodule

// File: rtl/nsr_seq.sv
// Request sequencer: alignment check, per-sector command/address/wait/data.
module nsr_seq
    import nsr_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned LW   = 32,
    parameter int unsigned DAW  = 32,
    parameter int unsigned SECT = 512
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [AW-1:0]  start_addr,
    input  logic [LW-1:0]  byte_len,
    input  logic [DAW-1:0] dst_base,
    input  logic           rdy_flag,
    output logic           busy,
    output logic           done,
    output logic           ok,
    output logic           ce_n,
    output logic           cmd_we,
    output logic           addr_we,
    output logic           data_re,
    output logic           mem_we,
    output logic [DAW-1:0] mem_addr,
    output logic           flag_clr,
    output logic [1:0]     aidx,
    output logic [AW-1:0]  cur_addr
);

    localparam int unsigned SCW = $clog2(SECT);
    localparam logic [SCW-1:0] COL_LAST = SCW'(SECT - 1);
    localparam logic [1:0]     AIDX_LAST = 2'(ADDR_CYCLES - 1);

    typedef struct packed {
        nsr_state_e     st;
        logic [AW:0]    cur;
        logic [AW:0]    fin;
        logic [DAW-1:0] dst;
        logic [SCW-1:0] col;
        logic [1:0]     aidx;
        logic           ok;
    } seq_t;

    seq_t r_q;
    seq_t r_d;

    logic        misaligned;
    logic        len_zero;
    logic [AW:0] cur_inc;

    assign misaligned = (|start_addr[SCW-1:0]) | (|byte_len[SCW-1:0]);
    assign len_zero   = (byte_len == '0);
    assign cur_inc    = r_q.cur + 1'b1;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (go) begin
                    r_d.cur  = {1'b0, start_addr};
                    r_d.fin  = {1'b0, start_addr} + (AW+1)'(byte_len);
                    r_d.dst  = dst_base;
                    r_d.col  = '0;
                    r_d.aidx = '0;
                    if (misaligned) begin
                        r_d.ok = 1'b0;
                        r_d.st = ST_FIN;
                    end else if (len_zero) begin
                        r_d.ok = 1'b1;
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.ok = 1'b1;
                        r_d.st = ST_CLR;
                    end
                end
            end
            ST_CLR: begin
                r_d.st = ST_CMD;
            end
            ST_CMD: begin
                r_d.aidx = '0;
                r_d.st   = ST_ADDR;
            end
            ST_ADDR: begin
                r_d.aidx = r_q.aidx + 1'b1;
                if (r_q.aidx == AIDX_LAST) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rdy_flag) begin
                    r_d.col = '0;
                    r_d.st  = ST_DATA;
                end
            end
            ST_DATA: begin
                r_d.cur = cur_inc;
                r_d.dst = r_q.dst + 1'b1;
                r_d.col = r_q.col + 1'b1;
                if (r_q.col == COL_LAST) begin
                    if (cur_inc == r_q.fin) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.st = ST_CLR;
                    end
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign done     = (r_q.st == ST_FIN);
    assign ok       = r_q.ok;
    assign ce_n     = !(r_q.st inside {ST_CLR, ST_CMD, ST_ADDR, ST_WAIT, ST_DATA});
    assign flag_clr = (r_q.st == ST_CLR);
    assign cmd_we   = (r_q.st == ST_CMD);
    assign addr_we  = (r_q.st == ST_ADDR);
    assign data_re  = (r_q.st == ST_DATA);
    assign mem_we   = (r_q.st == ST_DATA);
    assign mem_addr = r_q.dst;
    assign aidx     = r_q.aidx;
    assign cur_addr = r_q.cur[AW-1:0];

endmodule

// File: rtl/nand_sector_copier.sv
module nand_sector_copier
    import nsr_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned LW   = 32,
    parameter int unsigned DAW  = 32,
    parameter int unsigned DW   = 32,
    parameter int unsigned SECT = 512,
    parameter int unsigned SYNC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [AW-1:0]  start_addr,
    input  logic [LW-1:0]  byte_len,
    input  logic [DAW-1:0] dst_base,
    output logic           busy,
    output logic           done,
    output logic           ok,
    output logic           nf_ce_n,
    output logic           nf_cmd_we,
    output logic           nf_addr_we,
    output logic           nf_data_re,
    output logic [7:0]     nf_wdata,
    input  logic           nf_rdy,
    input  logic [DW-1:0]  nf_rdata,
    output logic           mem_we,
    output logic [DAW-1:0] mem_addr,
    output logic [7:0]     mem_wdata
);

    logic          rdy_flag;
    logic          flag_clr;
    logic [1:0]    aidx;
    logic [AW-1:0] cur_addr;
    logic [7:0]    abyte;
    logic          unused_rdata_hi;

    nsr_rdy_edge #(.STAGES(SYNC)) u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdy_async (nf_rdy),
        .flag_clr  (flag_clr),
        .flag      (rdy_flag)
    );

    nsr_addr_split #(.AW(AW)) u_split (
        .addr  (cur_addr),
        .idx   (aidx),
        .abyte (abyte)
    );

    nsr_seq #(
        .AW   (AW),
        .LW   (LW),
        .DAW  (DAW),
        .SECT (SECT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .start_addr (start_addr),
        .byte_len   (byte_len),
        .dst_base   (dst_base),
        .rdy_flag   (rdy_flag),
        .busy       (busy),
        .done       (done),
        .ok         (ok),
        .ce_n       (nf_ce_n),
        .cmd_we     (nf_cmd_we),
        .addr_we    (nf_addr_we),
        .data_re    (nf_data_re),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .flag_clr   (flag_clr),
        .aidx       (aidx),
        .cur_addr   (cur_addr)
    );

    assign nf_wdata        = nf_cmd_we ? PAGE_READ_OP : abyte;
    assign mem_wdata       = nf_rdata[7:0];
    assign unused_rdata_hi = ^nf_rdata[DW-1:8];

endmodule

// File: rtl/nsr_checker.sv
module nsr_checker #(
    parameter int unsigned LW   = 32,
    parameter int unsigned DAW  = 32,
    parameter int unsigned SECT = 512,
    localparam int unsigned SCW = $clog2(SECT)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           go,
    input logic [SCW-1:0] start_lo,
    input logic [LW-1:0]  byte_len,
    input logic [DAW-1:0] dst_base,
    input logic           busy,
    input logic           done,
    input logic           ok,
    input logic           nf_ce_n,
    input logic           nf_cmd_we,
    input logic           nf_addr_we,
    input logic           nf_data_re,
    input logic [7:0]     nf_wdata,
    input logic           nf_rdy,
    input logic [7:0]     rdata_lo,
    input logic           mem_we,
    input logic [DAW-1:0] mem_addr,
    input logic [7:0]     mem_wdata
);

    logic           rdy_q;
    logic           rise_seen_q;
    logic [DAW-1:0] exp_dst_q;
    logic           accept;
    logic           refused;

    assign accept  = go && !busy;
    assign refused = (start_lo != '0) || (byte_len[SCW-1:0] != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q       <= 1'b1;
            rise_seen_q <= 1'b0;
            exp_dst_q   <= '0;
        end else begin
            rdy_q <= nf_rdy;
            if (nf_cmd_we) begin
                rise_seen_q <= 1'b0;
            end else if (nf_rdy && !rdy_q) begin
                rise_seen_q <= 1'b1;
            end
            if (accept) begin
                exp_dst_q <= dst_base;
            end else if (mem_we) begin
                exp_dst_q <= exp_dst_q + 1'b1;
            end
        end
    end

    p_misalign_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept && refused |=> done && !ok && nf_ce_n);

    p_zero_len_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !refused && byte_len == '0 |=> done && ok && nf_ce_n);

    p_strobe_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nf_cmd_we || nf_addr_we || nf_data_re) |-> !nf_ce_n);

    p_ce_off_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || done) |-> nf_ce_n);

    p_cmd_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nf_cmd_we |-> nf_wdata == 8'h00);

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nf_cmd_we, nf_addr_we, nf_data_re}));

    p_ready_before_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nf_data_re |-> rise_seen_q);

    p_mem_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nf_data_re |-> mem_we && mem_wdata == rdata_lo);

    p_dst_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == exp_dst_q);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_go_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        go && busy && !done |=> busy);

endmodule

bind nand_sector_copier nsr_checker #(
    .LW   (LW),
    .DAW  (DAW),
    .SECT (SECT)
) u_nsr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .start_lo   (start_addr[$clog2(SECT)-1:0]),
    .byte_len   (byte_len),
    .dst_base   (dst_base),
    .busy       (busy),
    .done       (done),
    .ok         (ok),
    .nf_ce_n    (nf_ce_n),
    .nf_cmd_we  (nf_cmd_we),
    .nf_addr_we (nf_addr_we),
    .nf_data_re (nf_data_re),
    .nf_wdata   (nf_wdata),
    .nf_rdy     (nf_rdy),
    .rdata_lo   (nf_rdata[7:0]),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
);

// File: tb/test_nand_sector_copier.sv
`timescale 1ns/1ps
module test_nand_sector_copier;

    localparam int SECT = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [31:0] start_addr = '0;
    logic [31:0] byte_len = '0;
    logic [31:0] dst_base = '0;
    logic        busy, done, ok, nf_ce_n, nf_cmd_we, nf_addr_we, nf_data_re;
    logic [7:0]  nf_wdata;
    logic        nf_rdy = 1'b1;
    logic [31:0] nf_rdata;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;

    always #5 clk = ~clk;

    nand_sector_copier i_nand_sector_copier (
        .clk(clk), .rst_n(rst_n), .go(go), .start_addr(start_addr),
        .byte_len(byte_len), .dst_base(dst_base), .busy(busy), .done(done),
        .ok(ok), .nf_ce_n(nf_ce_n), .nf_cmd_we(nf_cmd_we),
        .nf_addr_we(nf_addr_we), .nf_data_re(nf_data_re), .nf_wdata(nf_wdata),
        .nf_rdy(nf_rdy), .nf_rdata(nf_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int n_checks = 0;
    int n_bad = 0;
    int cyc = 0;

    // Per-run observation counters (updated by the flash model/monitor)
    logic [31:0] run_start, run_dst;
    int  bytes_seen, cmds, addrs, dones, ce_falls, ce_early, strobe_no_ce;
    int  bad_cmd, bad_abyte, early_read, bad_data, bad_dst, sec_idx;
    bit  last_ok, ce_at_done, rise_since_cmd, stale_mode;
    int  busy_len, busy_left, stale_left, nab, col;
    int  exp_total;
    logic [7:0]  abytes [4];
    logic [31:0] model_base;
    logic        prev_ce_n = 1'b1;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return (a[7:0] + {a[8], 7'b0}) ^ a[16:9] ^ a[24:17] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] exp_abyte(input logic [31:0] a, input int k);
        logic [32:0] w;
        w = {1'b0, a};
        case (k)
            0: return w[7:0];
            1: return w[16:9];
            2: return w[24:17];
            default: return w[32:25];
        endcase
    endfunction

    assign nf_rdata = {8'hC3, 8'h99, 8'h3C, pat(model_base + 32'(col))};

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    endtask

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Flash model and monitor, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
        if (rst_n) begin
            if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) begin
                    nf_rdy = 1'b1;
                    rise_since_cmd = 1'b1;
                end
            end
            if (stale_left > 0) begin
                stale_left--;
                if (stale_left == 0) nf_rdy = 1'b1;
            end
            if (!nf_ce_n && prev_ce_n) ce_falls++;
            if (nf_ce_n && !prev_ce_n && bytes_seen != exp_total) ce_early++;
            prev_ce_n = nf_ce_n;
            if ((nf_cmd_we || nf_addr_we || nf_data_re) && nf_ce_n) strobe_no_ce++;
            if (nf_cmd_we) begin
                cmds++;
                if (nf_wdata != 8'h00) bad_cmd++;
                rise_since_cmd = 1'b0;
                nab = 0;
            end
            if (nf_addr_we) begin
                addrs++;
                if (nab < 4) begin
                    abytes[nab] = nf_wdata;
                    if (nf_wdata != exp_abyte(run_start + 32'(sec_idx * SECT), nab))
                        bad_abyte++;
                end
                nab++;
                if (nab == 4) begin
                    model_base = {abytes[3][6:0], abytes[2], abytes[1], 1'b0, abytes[0]};
                    col = 0;
                    sec_idx++;
                    nf_rdy = 1'b0;
                    busy_left = busy_len;
                end
            end
            if (nf_data_re) begin
                if (!rise_since_cmd) early_read++;
                if (!mem_we || mem_wdata != pat(run_start + 32'(bytes_seen))) bad_data++;
                if (mem_addr != run_dst + 32'(bytes_seen)) bad_dst++;
                bytes_seen++;
                col++;
                if (stale_mode && col == 500) begin
                    nf_rdy = 1'b0;
                    stale_left = 3;
                end
            end
            if (done) begin
                dones++;
                last_ok = ok;
                ce_at_done = nf_ce_n;
            end
        end
    end

    task automatic clear_run(input logic [31:0] s, input logic [31:0] l,
                             input logic [31:0] d, input int bl, input bit st);
        run_start = s; run_dst = d; busy_len = bl; stale_mode = st;
        bytes_seen = 0; cmds = 0; addrs = 0; dones = 0; ce_falls = 0; ce_early = 0;
        strobe_no_ce = 0; bad_cmd = 0; bad_abyte = 0; early_read = 0; bad_data = 0;
        bad_dst = 0; sec_idx = 0; nab = 0; last_ok = 0; ce_at_done = 0;
        rise_since_cmd = 0;
        exp_total = (l[8:0] == 0 && s[8:0] == 0) ? int'(l) : 0;
    endtask

    // Launch a request, optionally inject a second go while busy, wait for done
    task automatic run_req(input logic [31:0] s, input logic [31:0] l,
                           input logic [31:0] d, input int bl, input bit st,
                           input bit inject, input string req);
        int waited;
        clear_run(s, l, d, bl, st);
        @(posedge clk); #2;
        start_addr = s; byte_len = l; dst_base = d; go = 1'b1;
        @(posedge clk); #2;
        go = 1'b0;
        chk(busy == 1'b1, "R9", "busy after go", busy, 1);
        waited = 0;
        while (dones == 0) begin
            @(posedge clk); #2;
            waited++;
            if (inject && waited == 300) begin
                start_addr = 32'h0000_0101; byte_len = 32'd3; dst_base = 32'h0;
                go = 1'b1;
            end else begin
                go = 1'b0;
            end
        end
        chk(busy == 1'b0, "R9", "busy after done", busy, 0);
        repeat (3) @(posedge clk);
        #2;
        chk(dones == 1, req, "done pulses", dones, 1);
    endtask

    task automatic t_reset();
        chk(busy == 0, "R9", "reset busy", busy, 0);
        chk(done == 0, "R9", "reset done", done, 0);
        chk(nf_ce_n == 1, "R3", "reset ce_n", nf_ce_n, 1);
        chk({nf_cmd_we, nf_addr_we, nf_data_re, mem_we} == 4'b0, "R4", "reset strobes",
            {nf_cmd_we, nf_addr_we, nf_data_re, mem_we}, 0);
    endtask

    task automatic t_refused(input logic [31:0] s, input logic [31:0] l);
        run_req(s, l, 32'h100, 4, 1'b0, 1'b0, "R1");
        chk(last_ok == 0, "R1", "refused status", last_ok, 0);
        chk(ce_falls == 0, "R1", "ce asserted", ce_falls, 0);
        chk(cmds + addrs + bytes_seen == 0, "R1", "flash strobes",
            cmds + addrs + bytes_seen, 0);
    endtask

    task automatic t_zero();
        run_req(32'h0000_0400, 32'd0, 32'h200, 4, 1'b0, 1'b0, "R2");
        chk(last_ok == 1, "R2", "zero status", last_ok, 1);
        chk(ce_falls == 0, "R2", "ce asserted", ce_falls, 0);
        chk(cmds + addrs + bytes_seen == 0, "R2", "flash strobes",
            cmds + addrs + bytes_seen, 0);
    endtask

    task automatic t_copy(input logic [31:0] s, input int nsec, input logic [31:0] d,
                          input int bl, input bit st, input bit inject, input string req);
        run_req(s, 32'(nsec * SECT), d, bl, st, inject, req);
        chk(last_ok == 1, req, "status", last_ok, 1);
        chk(bytes_seen == nsec * SECT, "R7", "bytes read", bytes_seen, nsec * SECT);
        chk(bad_data == 0, "R7", "data mismatches", bad_data, 0);
        chk(bad_dst == 0, "R8", "dest addr mismatches", bad_dst, 0);
        chk(cmds == nsec, "R8", "sector count", cmds, nsec);
        chk(bad_cmd == 0, "R4", "bad command bytes", bad_cmd, 0);
        chk(addrs == 4 * nsec, "R5", "address cycles", addrs, 4 * nsec);
        chk(bad_abyte == 0, "R5", "address byte mismatches", bad_abyte, 0);
        chk(early_read == 0, "R6", "reads before ready rise", early_read, 0);
        chk(ce_falls == 1, "R3", "ce falls", ce_falls, 1);
        chk(ce_early == 0, "R3", "ce released early", ce_early, 0);
        chk(strobe_no_ce == 0, "R3", "strobes without ce", strobe_no_ce, 0);
        chk(ce_at_done == 1, "R3", "ce at done", ce_at_done, 1);
    endtask

    initial begin
        busy_left = 0; stale_left = 0; col = 0; model_base = '0;
        clear_run(0, 0, 0, 4, 0);
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        t_reset();
        t_refused(32'h0000_0100, 32'd512);
        t_refused(32'h0000_0000, 32'h0000_0300);
        t_zero();
        t_copy(32'h0A02_C200, 1, 32'h0000_1000, 6, 1'b0, 1'b0, "R5");
        t_copy(32'hFE00_0000, 1, 32'h8000_0000, 20, 1'b0, 1'b0, "R8");
        t_copy(32'h0123_4600, 3, 32'h0000_2000, 40, 1'b1, 1'b0, "R6");
        t_copy(32'h0000_0000, 2, 32'h0000_0010, 8, 1'b0, 1'b1, "R10");
        summary();
        $finish;
    end

endmodule